// File: doc/BRIEF.md
# Packet Container Packer

The packer takes received Ethernet frames as a byte stream and assembles them into a fixed-size container of 32-bit words held in a local buffer. The container starts with a header region. Word 0 of the header records how many words of the container are in use and how many packets it carries. The words after it hold a table of 16-bit byte lengths, two packets per word. Packet payloads follow the header. Each packet starts on a fresh word, and any unused bytes of its last word are zero.

Payload words are written while the bytes arrive. The length table is kept in registers and is written into the buffer only when the container is closed. Word 0 is the last word written, and a one-cycle container-full pulse follows it. Closing is decided after each accepted packet. The container closes when the packet count reaches its limit, or when the remaining data words could not hold a packet of the largest legal length. Some packets are discarded whole and counted: those that start while the next buffer slot is not free, those that start while a container is being closed, and those whose length falls outside the legal range.

Top module: `cpk_packer`

## Requirements
- R1: After reset, `buf_we` and `cont_full` are low and `drop_count` is zero.
- R2: The first accepted packet of a container begins at word `HDR_WORDS` = 1 + ceil(MAX_PKTS/2). Byte j of a packet that starts at data word s goes to buffer word `HDR_WORDS + s + j/4`, in bits [8*(j%4)+7 : 8*(j%4)].
- R3: Byte lanes past the end of a packet in its last word are written as zero. The next packet starts at the following word.
- R4: Header word k (k ≥ 1) holds the length of packet 2(k-1) in bits [31:16] and the length of packet 2k-1 in bits [15:0]. When that second packet does not exist, bits [15:0] are zero.
- R5: Header word 0 holds `HDR_WORDS` plus the number of data words used in bits [31:16], and the packet count in bits [15:0].
- R6: The container closes right after the packet that brings the count to `MAX_PKTS`, and not before.
- R7: The container closes right after a packet that leaves fewer than ceil(MAX_LEN/4) free data words. It stays open when exactly that many words remain.
- R8: On close, every table word is written before word 0. `cont_full` is high for exactly one cycle, in the cycle after the word-0 write.
- R9: A packet whose start byte arrives while `slot_free` is low produces no buffer write and increments `drop_count` by one.
- R10: A packet shorter than `MIN_LEN` or longer than `MAX_LEN` bytes is not counted in the container and increments `drop_count`. The next packet starts at the same word the dropped one did.
- R11: A packet whose start byte arrives while a container is being closed is dropped and counted. It does not appear in the following container.
- R12: Valid bytes that arrive outside a packet (no start seen) cause no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_sop | input | 1 | The byte is the first of a packet |
| in_eop | input | 1 | The byte is the last of a packet |
| in_byte | input | 8 | Packet byte |
| slot_free | input | 1 | A container slot is available to fill |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | $clog2(CONT_WORDS) | Buffer word address |
| buf_wdata | output | 32 | Buffer write data |
| cont_full | output | 1 | One-cycle pulse: container closed and complete |
| drop_count | output | DROP_W | Number of discarded packets |

## Verification
The bench builds the packer with a 64-word container, at most 8 packets, and legal lengths of 4 to 40 bytes. This gives a 5-word header, 59 data words, and a 10-word reserve for a maximum-length packet. With these values, a closure on packet count, a closure on remaining room, and the exact boundary where 10 free words keep the container open can all be reached in a few dozen packets. A shadow copy of the buffer is built from the write port alone. Each closed container is compared word by word with contents computed from the accepted lengths and a byte pattern, together with the order of the table and word-0 writes relative to the full pulse. Drops from a busy slot, from lengths that are too short or too long, and from a start during a close are mixed into the same run.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BODY  = 3'd1,
        ST_TABLE = 3'd2,
        ST_HEAD  = 3'd3,
        ST_DONE  = 3'd4
    } cpk_state_e;
endpackage

// File: rtl/cpk_lane_merge.sv
module cpk_lane_merge #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]         acc_i,
    input  logic [7:0]                 byte_i,
    input  logic [$clog2(LANES)-1:0]   lane_i,
    output logic [8*LANES-1:0]         word_o
);
    localparam int LW = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[8*g +: 8] = (lane_i == LW'(g)) ? byte_i : acc_i[8*g +: 8];
    end
endmodule

// File: rtl/cpk_len_table.sv
module cpk_len_table #(
    parameter int MAX_PKTS = 66,
    parameter int HALF_W   = 16,
    localparam int NPKT_W  = $clog2(MAX_PKTS + 1),
    localparam int NPAIRS  = (MAX_PKTS + 1) / 2,
    localparam int PAIR_W  = $clog2(NPAIRS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NPKT_W-1:0]    wr_idx,
    input  logic [HALF_W-1:0]    wr_len,
    input  logic [PAIR_W-1:0]    rd_pair,
    input  logic [NPKT_W-1:0]    rd_cnt,
    output logic [2*HALF_W-1:0]  rd_word
);
    logic [HALF_W-1:0] len_q [MAX_PKTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_PKTS; i++) len_q[i] <= '0;
        end else if (wr_en) begin
            len_q[wr_idx] <= wr_len;
        end
    end

    always_comb begin
        int hi_i;
        int lo_i;
        hi_i = 2 * int'(rd_pair);
        lo_i = hi_i + 1;
        rd_word = '0;
        if (hi_i < int'(rd_cnt) && hi_i < MAX_PKTS) rd_word[2*HALF_W-1:HALF_W] = len_q[hi_i];
        if (lo_i < int'(rd_cnt) && lo_i < MAX_PKTS) rd_word[HALF_W-1:0] = len_q[lo_i];
    end

    assert_tbl_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < MAX_PKTS));
endmodule

// File: rtl/cpk_packer.sv
module cpk_packer #(
    parameter int CONT_WORDS = 1024,
    parameter int MAX_PKTS   = 66,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1542,
    parameter int DROP_W     = 16,
    localparam int ADDR_W    = $clog2(CONT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_byte,
    input  logic              slot_free,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [31:0]       buf_wdata,
    output logic              cont_full,
    output logic [DROP_W-1:0] drop_count
);
    import cpk_pkg::*;

    localparam int HALF_W        = 16;
    localparam int HDR_WORDS     = 1 + (MAX_PKTS + 1) / 2;
    localparam int DATA_WORDS    = CONT_WORDS - HDR_WORDS;
    localparam int MAX_PKT_WORDS = (MAX_LEN + 3) / 4;
    localparam int PTR_W         = $clog2(CONT_WORDS + 1);
    localparam int NPKT_W        = $clog2(MAX_PKTS + 1);
    localparam int NPAIRS        = (MAX_PKTS + 1) / 2;
    localparam int PAIR_W        = $clog2(NPAIRS + 1);

    typedef struct packed {
        cpk_state_e        st;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  pstart;
        logic [1:0]        lane;
        logic [31:0]       acc;
        logic [HALF_W-1:0] plen;
        logic [NPKT_W-1:0] npkt;
        logic [PAIR_W-1:0] pair;
        logic [DROP_W-1:0] drops;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic              full;
    } cpk_regs_t;

    cpk_regs_t q, d;

    logic              tbl_we;
    logic [NPKT_W-1:0] tbl_idx;
    logic [HALF_W-1:0] tbl_len;
    logic [31:0]       tbl_word;
    logic [1:0]        cur_lane;
    logic [31:0]       cur_acc;
    logic [31:0]       merged;

    assign cur_lane = (q.st == ST_IDLE) ? 2'd0 : q.lane;
    assign cur_acc  = (q.st == ST_IDLE) ? 32'd0 : q.acc;

    cpk_lane_merge #(.LANES(4)) u_merge (
        .acc_i  (cur_acc),
        .byte_i (in_byte),
        .lane_i (cur_lane),
        .word_o (merged)
    );

    cpk_len_table #(.MAX_PKTS(MAX_PKTS), .HALF_W(HALF_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_len  (tbl_len),
        .rd_pair (q.pair),
        .rd_cnt  (q.npkt),
        .rd_word (tbl_word)
    );

    always_comb begin
        logic              first;
        logic              take;
        logic              fits;
        logic              close;
        logic [HALF_W-1:0] len_nx;
        logic [PTR_W-1:0]  wptr_nx;
        logic [NPKT_W-1:0] npkt_nx;
        logic [PAIR_W-1:0] last_pair;

        d       = q;
        d.we    = 1'b0;
        d.full  = 1'b0;
        tbl_we  = 1'b0;
        tbl_idx = q.npkt;
        tbl_len = '0;
        first   = (q.st == ST_IDLE);
        take    = 1'b0;
        len_nx  = first ? HALF_W'(1) : ((q.plen == '1) ? q.plen : q.plen + 1'b1);
        fits    = (int'(len_nx) <= MAX_LEN);
        wptr_nx = q.wptr;
        npkt_nx = q.npkt + 1'b1;
        close   = 1'b0;
        last_pair = PAIR_W'((int'(q.npkt) + 1) / 2 - 1);

        case (q.st)
            ST_IDLE: begin
                if (in_valid && in_sop) begin
                    if (!slot_free) d.drops = q.drops + 1'b1;
                    else            take = 1'b1;
                end
            end
            ST_BODY: take = in_valid;
            ST_TABLE: begin
                if (in_valid && in_sop) d.drops = q.drops + 1'b1;
                d.we    = 1'b1;
                d.addr  = ADDR_W'(1 + int'(q.pair));
                d.wdata = tbl_word;
                if (q.pair == last_pair) d.st = ST_HEAD;
                else                     d.pair = q.pair + 1'b1;
            end
            ST_HEAD: begin
                if (in_valid && in_sop) d.drops = q.drops + 1'b1;
                d.we    = 1'b1;
                d.addr  = '0;
                d.wdata = {HALF_W'(HDR_WORDS + int'(q.wptr)), HALF_W'(q.npkt)};
                d.st    = ST_DONE;
            end
            ST_DONE: begin
                if (in_valid && in_sop) d.drops = q.drops + 1'b1;
                d.full   = 1'b1;
                d.wptr   = '0;
                d.pstart = '0;
                d.npkt   = '0;
                d.pair   = '0;
                d.st     = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (take) begin
            d.st   = ST_BODY;
            d.plen = len_nx;
            if (first) d.pstart = q.wptr;
            if (cur_lane == 2'd3 || in_eop) begin
                d.lane = 2'd0;
                d.acc  = '0;
                if (fits) begin
                    d.we    = 1'b1;
                    d.addr  = ADDR_W'(HDR_WORDS + int'(q.wptr));
                    d.wdata = merged;
                    wptr_nx = q.wptr + 1'b1;
                end
            end else begin
                d.lane = cur_lane + 2'd1;
                d.acc  = merged;
            end
            d.wptr = wptr_nx;
            if (in_eop) begin
                if (fits && int'(len_nx) >= MIN_LEN) begin
                    tbl_we   = 1'b1;
                    tbl_len  = len_nx;
                    d.npkt   = npkt_nx;
                    d.pstart = wptr_nx;
                    close = (int'(npkt_nx) == MAX_PKTS) ||
                            ((DATA_WORDS - int'(wptr_nx)) < MAX_PKT_WORDS);
                    d.pair = '0;
                    d.st   = close ? ST_TABLE : ST_IDLE;
                end else begin
                    d.drops = q.drops + 1'b1;
                    d.wptr  = first ? q.wptr : q.pstart;
                    d.st    = ST_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign buf_we     = q.we;
    assign buf_addr   = q.addr;
    assign buf_wdata  = q.wdata;
    assign cont_full  = q.full;
    assign drop_count = q.drops;

    assert_full_after_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cont_full |-> $past(buf_we && buf_addr == '0));
    assert_full_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cont_full |=> !cont_full);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.wptr) <= DATA_WORDS);
    assert_count_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.npkt) <= MAX_PKTS);
    assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !(in_valid && in_sop)) |=> !buf_we);
endmodule

// File: tb/cpk_packer_tb_top.sv
module cpk_packer_tb_top;
    localparam int CW   = 64;
    localparam int MP   = 8;
    localparam int MINL = 4;
    localparam int MAXL = 40;
    localparam int HDR  = 1 + (MP + 1) / 2;
    localparam int AW   = $clog2(CW);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, slot_free = 1'b1;
    logic [7:0]  in_byte = '0;
    logic        buf_we, cont_full;
    logic [AW-1:0] buf_addr;
    logic [31:0] buf_wdata;
    logic [15:0] drop_count;

    cpk_packer #(.CONT_WORDS(CW), .MAX_PKTS(MP), .MIN_LEN(MINL), .MAX_LEN(MAXL), .DROP_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_byte(in_byte), .slot_free(slot_free), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .cont_full(cont_full), .drop_count(drop_count)
    );

    logic [31:0] bm [CW];
    int cyc = 0, wcount = 0, full_cnt = 0, word0_cyc = 0, tbl_cyc = 0, full_cyc = 0;
    int checks = 0, errors = 0, gid = 0, cn = 0, exp_full = 0, exp_drop = 0;
    int clen [16];
    int cid  [16];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && buf_we) begin
            bm[buf_addr] <= buf_wdata;
            wcount <= wcount + 1;
            if (buf_addr == '0) word0_cyc <= cyc;
            else if (int'(buf_addr) < HDR) tbl_cyc <= cyc;
        end
        if (rst_n && cont_full) begin
            full_cnt <= full_cnt + 1;
            full_cyc <= cyc;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int id, input int j);
        return 8'(id * 37 + j * 5 + 1);
    endfunction

    task automatic put(input logic v, input logic s, input logic e, input logic [7:0] b);
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_byte = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic send(input int len, input logic gaps, input logic keep);
        int id;
        id = gid++;
        for (int j = 0; j < len; j++) begin
            put(1'b1, j == 0, j == len - 1, pat(id, j));
            if (gaps && (j % 3 == 1) && j != len - 1) put(1'b0, 1'b0, 1'b0, 8'hEE);
        end
        if (keep) begin clen[cn] = len; cid[cn] = id; cn++; end
    endtask

    task automatic wait_full();
        int f0, t;
        f0 = full_cnt; t = 0;
        while (full_cnt == f0 && t < 300) begin @(negedge clk); t++; end
        idle(2);
    endtask

    task automatic check_cont(input string closereq);
        int s, nw;
        logic [31:0] e;
        exp_full++;
        chk(full_cnt == exp_full, closereq, full_cnt, exp_full);
        s = 0;
        for (int p = 0; p < cn; p++) begin
            nw = (clen[p] + 3) / 4;
            for (int w = 0; w < nw; w++) begin
                e = '0;
                for (int l = 0; l < 4; l++)
                    if (4 * w + l < clen[p]) e[8*l +: 8] = pat(cid[p], 4 * w + l);
                chk(bm[HDR + s + w] === e, (4 * w + 3 >= clen[p]) ? "R3" : "R2", bm[HDR + s + w], e);
            end
            s += nw;
        end
        for (int k = 0; k < (cn + 1) / 2; k++) begin
            e[31:16] = 16'(clen[2 * k]);
            e[15:0]  = (2 * k + 1 < cn) ? 16'(clen[2 * k + 1]) : 16'd0;
            chk(bm[1 + k] === e, "R4", bm[1 + k], e);
        end
        e = {16'(HDR + s), 16'(cn)};
        chk(bm[0] === e, "R5", bm[0], e);
        chk(full_cyc == word0_cyc + 1, "R8", full_cyc, word0_cyc + 1);
        chk(tbl_cyc < word0_cyc, "R8", tbl_cyc, word0_cyc);
        cn = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        idle(3);
        chk(buf_we == 1'b0 && cont_full == 1'b0, "R1", {buf_we, cont_full}, 0);
        chk(drop_count == 16'd0, "R1", drop_count, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // Container A: closes on packet count (R6); start during close dropped (R11)
        for (int i = 0; i < 7; i++) begin send(4 + i, i[0], 1'b1); idle(1); end
        idle(12);
        chk(full_cnt == exp_full, "R6", full_cnt, exp_full);
        send(11, 1'b0, 1'b1);
        send(8, 1'b0, 1'b0);
        exp_drop++;
        idle(1);
        wait_full();
        check_cont("R6");
        chk(drop_count == 16'(exp_drop), "R11", drop_count, exp_drop);

        // Container B: closes on room, odd count (R7, R4)
        for (int i = 0; i < 4; i++) begin send(40, i == 2, 1'b1); idle(1); end
        idle(12);
        chk(full_cnt == exp_full, "R7", full_cnt, exp_full);
        send(40, 1'b0, 1'b1); idle(1);
        wait_full();
        check_cont("R7");

        // Container C: exactly one maximum packet of room left stays open (R7)
        for (int i = 0; i < 4; i++) begin send(40, 1'b0, 1'b1); idle(1); end
        send(36, 1'b1, 1'b1); idle(12);
        chk(full_cnt == exp_full, "R7", full_cnt, exp_full);
        send(4, 1'b0, 1'b1); idle(1);
        wait_full();
        check_cont("R7");

        // Container D: length drops (R10), busy slot (R9), stray bytes (R12)
        send(8, 1'b0, 1'b1); idle(1);
        send(3, 1'b0, 1'b0); idle(2); exp_drop++;
        chk(drop_count == 16'(exp_drop), "R10", drop_count, exp_drop);
        send(12, 1'b0, 1'b1); idle(1);
        send(45, 1'b1, 1'b0); idle(2); exp_drop++;
        chk(drop_count == 16'(exp_drop), "R10", drop_count, exp_drop);
        slot_free = 1'b0;
        w0 = wcount;
        send(10, 1'b0, 1'b0); idle(3); exp_drop++;
        chk(wcount == w0, "R9", wcount, w0);
        chk(drop_count == 16'(exp_drop), "R9", drop_count, exp_drop);
        slot_free = 1'b1;
        w0 = wcount;
        for (int j = 0; j < 5; j++) put(1'b1, 1'b0, j == 4, 8'(j + 9));
        idle(3);
        chk(wcount == w0, "R12", wcount, w0);
        for (int i = 0; i < 6; i++) begin send(4, 1'b0, 1'b1); idle(1); end
        wait_full();
        check_cont("R6");
        chk(drop_count == 16'(exp_drop), "R10", drop_count, exp_drop);

        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule